// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Front End

This block is the register-access side of a two-channel serial communications controller. It sits on an 8-bit CPU bus. A 2-bit address picks a control port or a data port for channel A or channel B. Most registers are reached indirectly. The CPU first writes a register number to a control port, and the next control access to either channel uses that number. The pointer then falls back to zero. This means a plain control read with no setup always returns the first status register. A "point high" form of the pointer command reaches registers 8 through 15.

Each channel holds sixteen write registers and four status registers. A write to register 9 carries reset commands in its top two bits. These can reset channel A, reset channel B, or hardware-reset both channels. A channel reset clears or sets fixed masks across the write bank:
- register 0 is cleared;
- 0xDB is cleared in register 1, 0x01 in register 3, 0x9E in register 5 and 0x9F in register 10;
- bit 2 of register 4 is set;
- bit 5 of register 9 is cleared in both channels;
- bits 5:2 of register 14 are forced to 1000;
- register 15 becomes 0xF8.

A hardware reset applies the channel reset to both channels and then makes further changes:
- register 10 is cleared;
- register 11 becomes 0x08;
- bits 5:0 of register 14 become 100000;
- the upper six bits of register 9 become 110000.

A single data byte is shared by both data ports. A data write also raises the transmit-empty and receive-available flags of the channel that was written. Serial shifting, baud generation, DMA and interrupt priority are not part of this block.

Top module: `dual_sio_regs`

## Requirements
- R1: A synchronous active-high `rst` performs a hardware reset from an all-zero state. After it, in both channels:
  - the pointer is 0;
  - status 0 reads 0x44 and status 1 reads 0x06;
  - status 3 and status 10 read 0x00;
  - write register 15 reads 0xF8, and write registers 12, 13 and 2 read 0x00;
  - the data byte reads 0x00.
- R2: A control write while the pointer is 0 loads pointer bits 2:0 from data bits 2:0. It sets pointer bit 3 only when data bits 5:3 equal 001.
- R3: The pointer is one-shot and is shared by both channels. A control write with a nonzero pointer stores the byte into that register of the channel being addressed, then clears the pointer. A control read also clears the pointer.
- R4: A control read returns the following, and `rdata` is 0x00 whenever `rd_stb` is low:

  | Pointer | Returned value |
  |---|---|
  | 0, 1, 3, 10 | status registers 0, 1, 3, 10 of the addressed channel |
  | 12, 13, 15 | the stored write register of the addressed channel |
  | 2 | channel A's write register 2, from either port |
  | any other | 0x00 |

- R5: The address map is fixed. 0 is channel B control, 1 is channel A control, 2 is channel B data and 3 is channel A data. Each channel has its own register bank.
- R6: Writing register 9 decodes data bits 7:6 as follows. 01 resets channel B, 10 resets channel A, 11 hardware-resets both channels, and 00 changes nothing.
- R7: A channel reset has these effects:
  - status 0 becomes (old AND 0x38) OR 0x44;
  - status 1 becomes 0x06, and status 3 and status 10 become 0x00;
  - write register 15 becomes 0xF8;
  - write registers 12 and 13 are kept;
  - the other channel is left unchanged.
- R8: A hardware reset gives both channels the channel-reset result.
- R9: A data write stores the byte in the shared data buffer. It ORs 0x05 into status 0 of the written channel (bit 0 is receive available, bit 2 is transmit empty) and leaves the other channel alone. A data read from either port returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; performs a hardware reset |
| addr | input | 2 | Port select: bit 1 chooses data, bit 0 chooses channel A |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_stb` |

## Verification
The hardest state to reach from the ports is a channel-reset mask applied to a status register that already holds flags. The stimulus first raises the flags with a data write to that channel. It then issues the register 9 command through the opposite channel's control port, which also exercises the shared pointer. It reads status 0 of both channels to confirm that only the target channel was masked. The separation between channels is observed through register 15, which was given a different value in each channel before the reset.

// File: rtl/dual_sio_regs.sv
module dual_sio_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] addr,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int CH_A = 0;
  localparam int CH_B = 1;

  logic [3:0] ptr;
  logic [7:0] wr_bank [2][16];
  logic [7:0] rr0 [2];
  logic [7:0] rr1 [2];
  logic [7:0] rr3 [2];
  logic [7:0] rr10 [2];
  logic [7:0] dbuf;

  logic       ch;
  logic       ctl_wr, ctl_rd, data_wr, reg_store, hw_cmd;
  logic [1:0] rst_cmd, chan_rst;

  assign ch        = ~addr[0];
  assign ctl_wr    = wr_stb & ~addr[1];
  assign ctl_rd    = rd_stb & ~addr[1] & ~wr_stb;
  assign data_wr   = wr_stb & addr[1];
  assign reg_store = ctl_wr && (ptr != 4'd0);
  assign rst_cmd   = (reg_store && ptr == 4'd9) ? wdata[7:6] : 2'b00;
  assign hw_cmd    = (rst_cmd == 2'b11);
  assign chan_rst[CH_A] = rst_cmd[1];
  assign chan_rst[CH_B] = rst_cmd[0];

  always_comb begin
    rdata = 8'h00;
    if (rd_stb) begin
      if (addr[1]) rdata = dbuf;
      else begin
        case (ptr)
          4'd0:  rdata = rr0[ch];
          4'd1:  rdata = rr1[ch];
          4'd3:  rdata = rr3[ch];
          4'd10: rdata = rr10[ch];
          4'd12, 4'd13, 4'd15: rdata = wr_bank[ch][ptr];
          4'd2:  rdata = wr_bank[CH_A][2];
          default: rdata = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= 4'd0;
    else if (ctl_wr) ptr <= (ptr == 4'd0) ? {(wdata[5:3] == 3'b001), wdata[2:0]} : 4'd0;
    else if (ctl_rd) ptr <= 4'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < 16; r++) wr_bank[c][r] <= 8'h00;
        wr_bank[c][4]  <= 8'h04;
        wr_bank[c][9]  <= 8'hC0;
        wr_bank[c][11] <= 8'h08;
        wr_bank[c][14] <= 8'h20;
        wr_bank[c][15] <= 8'hF8;
        rr0[c]  <= 8'h44;
        rr1[c]  <= 8'h06;
        rr3[c]  <= 8'h00;
        rr10[c] <= 8'h00;
      end
      dbuf <= 8'h00;
    end else begin
      if (data_wr) begin
        dbuf    <= wdata;
        rr0[ch] <= rr0[ch] | 8'h05;
      end
      if (reg_store) begin
        if (ptr == 4'd9) begin
          for (int c = 0; c < 2; c++)
            wr_bank[c][9] <= (rst_cmd == 2'b00) ? wdata :
                             hw_cmd ? ((wdata & 8'h03) | 8'hC0) : (wdata & ~8'h20);
        end else begin
          wr_bank[ch][ptr] <= wdata;
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (chan_rst[c]) begin
          wr_bank[c][0]  <= 8'h00;
          wr_bank[c][1]  <= wr_bank[c][1] & ~8'hDB;
          wr_bank[c][3]  <= wr_bank[c][3] & ~8'h01;
          wr_bank[c][4]  <= wr_bank[c][4] | 8'h04;
          wr_bank[c][5]  <= wr_bank[c][5] & ~8'h9E;
          wr_bank[c][10] <= hw_cmd ? 8'h00 : (wr_bank[c][10] & ~8'h9F);
          wr_bank[c][11] <= hw_cmd ? 8'h08 : wr_bank[c][11];
          wr_bank[c][14] <= hw_cmd ? ((wr_bank[c][14] & 8'hC0) | 8'h20)
                                   : ((wr_bank[c][14] & ~8'h3C) | 8'h20);
          wr_bank[c][15] <= 8'hF8;
          rr0[c]  <= (rr0[c] & ~8'hC7) | 8'h44;
          rr1[c]  <= 8'h06;
          rr3[c]  <= 8'h00;
          rr10[c] <= 8'h00;
        end
      end
    end
  end
endmodule

// File: rtl/dual_sio_regs_chk.sv
module dual_sio_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] addr,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [3:0] ptr
);
  AST_PTR_ZERO_AFTER_RST: assert property (@(posedge clk) rst |=> ptr == 4'd0); // R1
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !addr[1] && ptr == 4'd0) |=>
      ptr == {($past(wdata[5:3]) == 3'b001), $past(wdata[2:0])}); // R2
  AST_PTR_ONESHOT_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !addr[1] && ptr != 4'd0) |=> ptr == 4'd0); // R3
  AST_PTR_ONESHOT_RD: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && !addr[1]) |=> ptr == 4'd0); // R3
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |-> rdata == 8'h00); // R4
  AST_DATA_READBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_stb && addr[1]) && rd_stb && !wr_stb && addr[1]) |-> rdata == $past(wdata)); // R9
endmodule

bind dual_sio_regs dual_sio_regs_chk i_chk (.*);

// File: tb/test_dual_sio_regs.sv
module test_dual_sio_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr_stb = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_sio_regs i_dual_sio_regs (.*);

  localparam int A = 0;
  localparam int B = 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(input int ch, input logic [7:0] v);
    @(negedge clk);
    addr = (ch == A) ? 2'd1 : 2'd0; wdata = v; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic ctl_rd(input int ch, output logic [7:0] v);
    @(negedge clk);
    addr = (ch == A) ? 2'd1 : 2'd0; rd_stb = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic dat_wr(input int ch, input logic [7:0] v);
    @(negedge clk);
    addr = (ch == A) ? 2'd3 : 2'd2; wdata = v; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic dat_rd(input int ch, output logic [7:0] v);
    @(negedge clk);
    addr = (ch == A) ? 2'd3 : 2'd2; rd_stb = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  function automatic logic [7:0] sel(input int r);
    return (r < 8) ? 8'(r) : (8'h08 | 8'(r & 7));
  endfunction

  task automatic reg_wr(input int ch, input int r, input logic [7:0] v);
    ctl_wr(ch, sel(r));
    ctl_wr(ch, v);
  endtask

  task automatic reg_rd(input int ch, input int r, output logic [7:0] v);
    if (r != 0) ctl_wr(ch, sel(r));
    ctl_rd(ch, v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    #1 chk("R4 idle rdata", rdata, 8'h00);
    reg_rd(A, 0, v);  chk("R1 RR0 A", v, 8'h44);
    reg_rd(B, 0, v);  chk("R1 RR0 B", v, 8'h44);
    reg_rd(B, 1, v);  chk("R1 RR1 B", v, 8'h06);
    reg_rd(A, 3, v);  chk("R1 RR3 A", v, 8'h00);
    reg_rd(B, 10, v); chk("R1 RR10 B", v, 8'h00);
    reg_rd(A, 15, v); chk("R1 WR15 A", v, 8'hF8);
    reg_rd(B, 12, v); chk("R1 WR12 B", v, 8'h00);
    reg_rd(A, 2, v);  chk("R1 WR2", v, 8'h00);
    dat_rd(A, v);     chk("R1 data buffer", v, 8'h00);
  endtask

  task automatic t_pointer;
    logic [7:0] v;
    reg_wr(A, 12, 8'h5A);
    reg_rd(A, 12, v); chk("R3 WR12 A stored", v, 8'h5A);
    ctl_rd(A, v);     chk("R3 pointer cleared after read", v, 8'h44);
    reg_wr(B, 13, 8'hC3);
    reg_rd(B, 13, v); chk("R5 WR13 B stored", v, 8'hC3);
    reg_rd(B, 12, v); chk("R5 WR12 B separate bank", v, 8'h00);
    ctl_wr(A, 8'h0C); ctl_wr(B, 8'h77);
    reg_rd(B, 12, v); chk("R3 shared pointer hits B", v, 8'h77);
    reg_rd(A, 12, v); chk("R3 shared pointer A kept", v, 8'h5A);
    ctl_wr(A, 8'h11); ctl_rd(A, v);
    chk("R2 no point-high when bits5:3=010", v, 8'h06);
    ctl_wr(B, 8'h0A); ctl_rd(B, v);
    chk("R2 point-high reaches RR10", v, 8'h00);
    ctl_wr(A, 8'h0F); ctl_rd(A, v);
    chk("R2 point-high reaches WR15", v, 8'hF8);
    reg_rd(A, 5, v);  chk("R4 undefined ptr 5 reads zero", v, 8'h00);
    ctl_rd(A, v);     chk("R4 pointer cleared after undefined read", v, 8'h44);
    reg_rd(B, 8, v);  chk("R4 ptr 8 reads zero", v, 8'h00);
    reg_wr(A, 2, 8'h3C);
    reg_wr(B, 2, 8'h99);
    reg_rd(B, 2, v);  chk("R4 vector from B port is channel A", v, 8'h3C);
    reg_rd(A, 2, v);  chk("R4 vector from A port", v, 8'h3C);
  endtask

  task automatic t_data;
    logic [7:0] v;
    dat_wr(A, 8'hA5);
    dat_rd(B, v);    chk("R9 shared buffer via B", v, 8'hA5);
    dat_rd(A, v);    chk("R9 buffer via A", v, 8'hA5);
    reg_rd(A, 0, v); chk("R9 RR0 A flags", v, 8'h45);
    reg_rd(B, 0, v); chk("R9 RR0 B untouched", v, 8'h44);
    dat_wr(B, 8'h3E);
    dat_rd(A, v);    chk("R5 data port B address", v, 8'h3E);
  endtask

  task automatic t_chan_reset;
    logic [7:0] v;
    reg_wr(A, 12, 8'h11);
    reg_wr(A, 15, 8'h34);
    reg_wr(B, 15, 8'h12);
    reg_wr(A, 9, 8'h40);
    reg_rd(B, 0, v);  chk("R7 RR0 B after B reset", v, 8'h44);
    reg_rd(B, 15, v); chk("R7 WR15 B after B reset", v, 8'hF8);
    reg_rd(B, 13, v); chk("R7 WR13 B kept", v, 8'hC3);
    reg_rd(A, 0, v);  chk("R6 RR0 A untouched by B reset", v, 8'h45);
    reg_rd(A, 15, v); chk("R6 WR15 A untouched by B reset", v, 8'h34);
    reg_wr(B, 9, 8'h80);
    reg_rd(A, 0, v);  chk("R7 RR0 A after A reset", v, 8'h44);
    reg_rd(A, 15, v); chk("R7 WR15 A after A reset", v, 8'hF8);
    reg_rd(A, 12, v); chk("R7 WR12 A kept", v, 8'h11);
    reg_rd(A, 1, v);  chk("R7 RR1 A", v, 8'h06);
    reg_wr(A, 15, 8'h55);
    dat_wr(A, 8'h01);
    reg_wr(A, 9, 8'h00);
    reg_rd(A, 15, v); chk("R6 code 00 keeps WR15", v, 8'h55);
    reg_rd(A, 0, v);  chk("R6 code 00 keeps RR0", v, 8'h45);
  endtask

  task automatic t_hw_reset;
    logic [7:0] v;
    reg_wr(B, 15, 8'h66);
    dat_wr(B, 8'h02);
    reg_wr(B, 9, 8'hC0);
    reg_rd(A, 15, v); chk("R8 WR15 A", v, 8'hF8);
    reg_rd(B, 15, v); chk("R8 WR15 B", v, 8'hF8);
    reg_rd(A, 0, v);  chk("R8 RR0 A", v, 8'h44);
    reg_rd(B, 0, v);  chk("R8 RR0 B", v, 8'h44);
    reg_rd(A, 12, v); chk("R8 WR12 A kept", v, 8'h11);
  endtask

  task automatic t_bus_reset;
    logic [7:0] v;
    ctl_wr(A, 8'h0C);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ctl_rd(A, v);     chk("R1 pointer zero after bus reset", v, 8'h44);
    reg_rd(A, 12, v); chk("R1 WR12 A cleared", v, 8'h00);
    dat_rd(B, v);     chk("R1 buffer cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pointer();
    t_data();
    t_chan_reset();
    t_hw_reset();
    t_bus_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule